// File: doc/BRIEF.md
# Multi-Mode DMA Channel Arbiter

This block decides which of six DMA channels owns the bus next. Each channel raises a request line. A 2-bit priority-mode field, taken from bits 9..8 of the global DMA control word, selects one of four policies at run time. Three are fixed priority orderings. The fourth is a two-tier rotating scheme: channels 0 to 3 form the upper tier and channels 4 and 5 form the lower tier. A global enable gates the whole arbiter.

A grant is registered and then held until the owning transfer reaches its end. In single mode that end is one acknowledged transfer unit. In block mode it is the end of the whole block. Each tier keeps a rotation pointer. The pointer moves past a channel only when a transfer unit of that channel is acknowledged as done. The block leaves address generation, data movement and register decoding to its neighbours.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After a synchronous reset, `gnt_vld` is 0, `gnt` is all zeros and `gnt_idx` is 0. Both rotation pointers point at the lowest channel of their tier: channel 0 for the upper tier and channel 4 for the lower tier.
- R2: While `dma_en` is 0, no grant is issued. If a grant is active when `dma_en` is sampled low, `gnt_vld` is 0 from the next cycle on, and the rotation pointers do not move.
- R3: With `prio_mode` = 0, the arbiter grants the lowest-numbered requesting channel (order 0,1,2,3,4,5).
- R4: With `prio_mode` = 1, the priority order from highest to lowest is 0,2,3,1,4,5.
- R5: With `prio_mode` = 2, the priority order from highest to lowest is 2,0,1,3,4,5.
- R6: With `prio_mode` = 3, any request from channels 0..3 wins over every request from channels 4..5.
- R7: With `prio_mode` = 3, the search inside each tier starts at that tier's pointer and wraps within the tier. When `unit_done` is sampled high during a grant, the pointer of the granted channel's tier moves to the channel after it, wrapping within the tier. Without `unit_done`, the pointer does not move.
- R8: While a grant is active, `gnt` and `gnt_idx` stay stable whatever the requests do. The `blk_mode` value latched at grant time decides when the grant ends. When it is 0, the grant is released on `unit_done`. When it is 1, `unit_done` is ignored and the grant is released on `block_done`.
- R9: Requests sampled at a clock edge while idle and enabled produce the grant at that edge. `gnt` is one-hot with bit `gnt_idx` set, and only a requesting channel is granted. A released grant leaves at least one idle cycle before the next grant.
- R10: With no request present and no active grant, `gnt_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Global DMA enable |
| prio_mode | input | 2 | Priority policy (control bits 9..8): 0 ascending, 1 and 2 fixed orders, 3 two-tier rotation |
| req | input | 6 | Per-channel request, bit n for channel n |
| blk_mode | input | 1 | Requested transfer is block mode, latched at grant |
| unit_done | input | 1 | Current transfer unit acknowledged done |
| block_done | input | 1 | Current block transfer finished |
| gnt | output | 6 | One-hot grant |
| gnt_idx | output | 3 | Index of granted channel |
| gnt_vld | output | 1 | A grant is active |

## Verification
The assertions check several properties on every cycle: the one-hot shape of the grant and its agreement with the index, that only a requester is granted, that grants stop after the enable drops, grant stability until a done strobe, upper-tier dominance in rotation mode, and the ascending order of mode 0. The bench scenarios are needed for the irregular orders of modes 1 and 2, for the pointer sequence across several grants (including the case where a grant is withdrawn with no acknowledged unit), and for the block-mode case where a unit strobe must not end the grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int MAX_CH = 8;

  typedef enum logic [1:0] {
    PM_ASCEND = 2'd0,
    PM_ORDER_A = 2'd1,
    PM_ORDER_B = 2'd2,
    PM_ROTATE = 2'd3
  } prio_mode_e;

  // Channel at priority position pos (0 = highest) for a fixed policy.
  // Positions that name channels above the configured count are skipped by the caller.
  function automatic logic [2:0] order_ch(input logic [1:0] mode, input logic [2:0] pos);
    logic [2:0] ch;
    case (mode)
      PM_ORDER_A: begin
        case (pos)
          3'd0: ch = 3'd0;
          3'd1: ch = 3'd2;
          3'd2: ch = 3'd3;
          3'd3: ch = 3'd1;
          3'd4: ch = 3'd4;
          3'd5: ch = 3'd6;
          3'd6: ch = 3'd7;
          default: ch = 3'd5;
        endcase
      end
      PM_ORDER_B: begin
        case (pos)
          3'd0: ch = 3'd2;
          3'd1: ch = 3'd0;
          3'd2: ch = 3'd1;
          3'd3: ch = 3'd3;
          3'd4: ch = 3'd6;
          3'd5: ch = 3'd4;
          3'd6: ch = 3'd5;
          default: ch = 3'd7;
        endcase
      end
      default: ch = pos;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [1:0]        mode,
  input  logic [NUM_CH-1:0] req,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [MAX_CH-1:0] req_ext;

  assign req_ext = MAX_CH'(req);

  // Walk from lowest to highest priority so the last match wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int p = MAX_CH - 1; p >= 0; p--) begin
      logic [2:0] ch;
      ch = order_ch(mode, 3'(p));
      if (req_ext[ch]) begin
        hit = 1'b1;
        idx = IDX_W'(ch);
      end
    end
  end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
  parameter int BASE  = 0,
  parameter int SIZE  = 4,
  parameter int IDX_W = 3,
  parameter int PTR_W = (SIZE > 1) ? $clog2(SIZE) : 1
) (
  input  logic [SIZE-1:0]  req,
  input  logic [PTR_W-1:0] ptr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Search starting at ptr, wrapping inside the tier; nearest offset wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = SIZE - 1; k >= 0; k--) begin
      int o;
      o = (int'(ptr) + k) % SIZE;
      if (req[o]) begin
        hit = 1'b1;
        idx = IDX_W'(BASE + o);
      end
    end
  end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int HI_SIZE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_en,
  input  logic [1:0]        prio_mode,
  input  logic [NUM_CH-1:0] req,
  input  logic              blk_mode,
  input  logic              unit_done,
  input  logic              block_done,
  output logic [NUM_CH-1:0] gnt,
  output logic [$clog2(NUM_CH)-1:0] gnt_idx,
  output logic              gnt_vld
);

  localparam int IDX_W   = $clog2(NUM_CH);
  localparam int LO_SIZE = NUM_CH - HI_SIZE;
  localparam int HP_W    = (HI_SIZE > 1) ? $clog2(HI_SIZE) : 1;
  localparam int LP_W    = (LO_SIZE > 1) ? $clog2(LO_SIZE) : 1;

  logic [HP_W-1:0]  ptr_hi;
  logic [LP_W-1:0]  ptr_lo;
  logic             fx_hit, hi_hit, lo_hit, cand_hit;
  logic [IDX_W-1:0] fx_idx, hi_idx, lo_idx, cand_idx;
  logic             held_blk;
  logic             release_now;
  logic             ptr_step;
  logic             in_hi;

  dma_arb_fixed_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_fixed (
    .mode (prio_mode),
    .req  (req),
    .hit  (fx_hit),
    .idx  (fx_idx)
  );

  dma_arb_rr_pick #(.BASE(0), .SIZE(HI_SIZE), .IDX_W(IDX_W), .PTR_W(HP_W)) u_rr_hi (
    .req (req[HI_SIZE-1:0]),
    .ptr (ptr_hi),
    .hit (hi_hit),
    .idx (hi_idx)
  );

  assign ptr_step = gnt_vld && unit_done;
  assign in_hi    = int'(gnt_idx) < HI_SIZE;

  generate
    if (LO_SIZE > 0) begin : g_lo_tier
      dma_arb_rr_pick #(.BASE(HI_SIZE), .SIZE(LO_SIZE), .IDX_W(IDX_W), .PTR_W(LP_W)) u_rr_lo (
        .req (req[NUM_CH-1:HI_SIZE]),
        .ptr (ptr_lo),
        .hit (lo_hit),
        .idx (lo_idx)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          ptr_lo <= '0;
        end else if (ptr_step && !in_hi) begin
          ptr_lo <= LP_W'((int'(gnt_idx) - HI_SIZE + 1) % LO_SIZE);
        end
      end
    end else begin : g_no_lo_tier
      assign lo_hit = 1'b0;
      assign lo_idx = '0;
      assign ptr_lo = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi <= '0;
    end else if (ptr_step && in_hi) begin
      ptr_hi <= HP_W'((int'(gnt_idx) + 1) % HI_SIZE);
    end
  end

  // Policy select: upper tier first in rotation mode.
  always_comb begin
    if (prio_mode == PM_ROTATE) begin
      cand_hit = hi_hit || lo_hit;
      cand_idx = hi_hit ? hi_idx : lo_idx;
    end else begin
      cand_hit = fx_hit;
      cand_idx = fx_idx;
    end
  end

  assign release_now = held_blk ? block_done : unit_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld  <= 1'b0;
      gnt      <= '0;
      gnt_idx  <= '0;
      held_blk <= 1'b0;
    end else if (!dma_en) begin
      gnt_vld <= 1'b0;
      gnt     <= '0;
    end else if (gnt_vld) begin
      if (release_now) begin
        gnt_vld <= 1'b0;
        gnt     <= '0;
      end
    end else if (cand_hit) begin
      gnt_vld  <= 1'b1;
      gnt      <= NUM_CH'(1) << cand_idx;
      gnt_idx  <= cand_idx;
      held_blk <= blk_mode;
    end
  end

endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter int NUM_CH  = 6,
  parameter int HI_SIZE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              dma_en,
  input logic [1:0]        prio_mode,
  input logic [NUM_CH-1:0] req,
  input logic              unit_done,
  input logic              block_done,
  input logic [NUM_CH-1:0] gnt,
  input logic [$clog2(NUM_CH)-1:0] gnt_idx,
  input logic              gnt_vld
);

  // R9
  grant_shape_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> ($onehot(gnt) && gnt[gnt_idx]));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !gnt_vld |-> (gnt == '0));

  // R9
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_vld) |-> (($past(req) & gnt) != '0));

  // R2
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !gnt_vld);

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld && dma_en && !unit_done && !block_done) |=> (gnt_vld && $stable(gnt) && $stable(gnt_idx)));

  // R10
  no_request_chk: assert property (@(posedge clk) disable iff (rst)
    (!gnt_vld && req == '0) |=> !gnt_vld);

  // R6
  upper_tier_chk: assert property (@(posedge clk) disable iff (rst)
    (!gnt_vld && dma_en && prio_mode == 2'd3 && req[HI_SIZE-1:0] != '0)
      |=> (gnt_vld && int'(gnt_idx) < HI_SIZE));

  // R3
  ascend_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!gnt_vld && dma_en && prio_mode == 2'd0 && req != '0)
      |=> (gnt == ($past(req) & (~$past(req) + NUM_CH'(1)))));

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NUM_CH(NUM_CH), .HI_SIZE(HI_SIZE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dma_en     (dma_en),
  .prio_mode  (prio_mode),
  .req        (req),
  .unit_done  (unit_done),
  .block_done (block_done),
  .gnt        (gnt),
  .gnt_idx    (gnt_idx),
  .gnt_vld    (gnt_vld)
);

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dma_en = 1'b0;
  logic [1:0] prio_mode = 2'd0;
  logic [5:0] req = '0;
  logic       blk_mode = 1'b0;
  logic       unit_done = 1'b0;
  logic       block_done = 1'b0;
  logic [5:0] gnt;
  logic [2:0] gnt_idx;
  logic       gnt_vld;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_chan_arbiter i_dma_chan_arbiter (
    .clk        (clk),
    .rst        (rst),
    .dma_en     (dma_en),
    .prio_mode  (prio_mode),
    .req        (req),
    .blk_mode   (blk_mode),
    .unit_done  (unit_done),
    .block_done (block_done),
    .gnt        (gnt),
    .gnt_idx    (gnt_idx),
    .gnt_vld    (gnt_vld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Value encoding the bench compares: valid flag in bit 8, one-hot in 5..0, index in 11..9.
  function automatic int enc(input logic v, input logic [2:0] i, input logic [5:0] g);
    return (int'(i) << 9) | (int'(v) << 8) | int'(g);
  endfunction

  task automatic check_grant(input int exp, input string tag);
    int want;
    want = enc(1'b1, 3'(exp), 6'(1 << exp));
    check(enc(gnt_vld, gnt_idx, gnt) == want, tag, enc(gnt_vld, gnt_idx, gnt), want);
  endtask

  task automatic check_idle(input string tag);
    check(!gnt_vld && gnt == '0, tag, enc(gnt_vld, gnt_idx, gnt), 0);
  endtask

  // One granted unit: request, check the grant, acknowledge, check the release.
  task automatic grant_unit(input logic [1:0] m, input logic [5:0] r, input int exp, input string tag);
    @(negedge clk);
    prio_mode = m; req = r; dma_en = 1'b1; blk_mode = 1'b0;
    @(posedge clk); #1;
    check_grant(exp, tag);
    @(negedge clk); unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0; req = '0;
    check_idle({tag, " release"});
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    check_idle("R1 reset outputs");
    check(gnt_idx == 3'd0, "R1 reset index", int'(gnt_idx), 0);
  endtask

  task automatic t_rotate;
    grant_unit(2'd3, 6'b001111, 0, "R1 R7 upper pointer starts at 0");
    grant_unit(2'd3, 6'b001111, 1, "R7 upper step 1");
    grant_unit(2'd3, 6'b001111, 2, "R7 upper step 2");
    grant_unit(2'd3, 6'b001111, 3, "R7 upper step 3");
    grant_unit(2'd3, 6'b001111, 0, "R7 upper wrap");
    grant_unit(2'd3, 6'b110000, 4, "R1 R7 lower pointer starts at 4");
    grant_unit(2'd3, 6'b110000, 5, "R7 lower step");
    grant_unit(2'd3, 6'b110000, 4, "R7 lower wrap");
    grant_unit(2'd3, 6'b100100, 2, "R6 upper tier beats lower");
    grant_unit(2'd3, 6'b010001, 0, "R6 upper tier beats lower wrap");
  endtask

  task automatic t_no_advance;
    // upper pointer is now 1; grant 1 then withdraw it without an acknowledged unit
    @(negedge clk);
    prio_mode = 2'd3; req = 6'b001110; dma_en = 1'b1;
    @(posedge clk); #1;
    check_grant(1, "R7 grant before withdraw");
    @(negedge clk); dma_en = 1'b0;
    @(posedge clk); #1;
    check_idle("R2 grant dropped when enable low");
    @(posedge clk); #1;
    check_idle("R2 no grant while enable low");
    grant_unit(2'd3, 6'b001110, 1, "R7 pointer unchanged without unit done");
  endtask

  task automatic t_fixed;
    grant_unit(2'd0, 6'b111110, 1, "R3 ascending");
    grant_unit(2'd0, 6'b101000, 3, "R3 ascending sparse");
    grant_unit(2'd0, 6'b100000, 5, "R3 last channel");
    grant_unit(2'd1, 6'b001110, 2, "R4 2 over 1 and 3");
    grant_unit(2'd1, 6'b001010, 3, "R4 3 over 1");
    grant_unit(2'd1, 6'b110010, 1, "R4 1 over 4 and 5");
    grant_unit(2'd1, 6'b110000, 4, "R4 4 over 5");
    grant_unit(2'd2, 6'b111111, 2, "R5 2 first");
    grant_unit(2'd2, 6'b001011, 0, "R5 0 over 1 and 3");
    grant_unit(2'd2, 6'b111010, 1, "R5 1 over 3");
    grant_unit(2'd2, 6'b110000, 4, "R5 4 over 5");
  endtask

  task automatic t_hold;
    @(negedge clk);
    prio_mode = 2'd0; req = 6'b100000; dma_en = 1'b1; blk_mode = 1'b0;
    @(posedge clk); #1;
    check_grant(5, "R9 grant at first edge");
    @(negedge clk); req = 6'b000001;
    @(posedge clk); #1;
    check_grant(5, "R8 single grant held against higher request");
    @(negedge clk); unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
    check_idle("R8 single released by unit done");
    @(posedge clk); #1;
    check_grant(0, "R9 next grant after one idle cycle");
    @(negedge clk); unit_done = 1'b1; req = '0;
    @(negedge clk); unit_done = 1'b0;
  endtask

  task automatic t_block;
    @(negedge clk);
    prio_mode = 2'd0; req = 6'b000100; dma_en = 1'b1; blk_mode = 1'b1;
    @(posedge clk); #1;
    check_grant(2, "R8 block grant");
    @(negedge clk); blk_mode = 1'b0; req = 6'b000001; unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
    check_grant(2, "R8 block grant ignores unit done");
    @(negedge clk); block_done = 1'b1;
    @(negedge clk); block_done = 1'b0; req = '0;
    check_idle("R8 block released by block done");
  endtask

  task automatic t_no_req;
    @(negedge clk); req = '0; dma_en = 1'b1; prio_mode = 2'd3;
    repeat (3) @(posedge clk);
    #1;
    check_idle("R10 idle with no requests");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_rotate();
    t_no_advance();
    t_fixed();
    t_hold();
    t_block();
    t_no_req();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule